// File: doc/BRIEF.md
# Motion Tensor Builder Pipeline

This block is one step of a dense optical-flow engine. For every pixel it receives two sets of quadratic-fit coefficients, one from the earlier frame and one from the later frame. From their differences it forms a symmetric 2x2 local-shape matrix A and a 2-element linear-term difference vector. It then produces the three distinct entries of the symmetric product G = A·A and the vector h = A·(difference vector). A later averaging and solve stage turns these into a displacement.

Each frame's coefficients arrive as one packed word on their own valid/ready channel. A pixel is taken only when both channels present data in the same cycle. Results leave on a single valid/ready channel after a fixed three-stage pipeline. When the consumer holds ready low, every stage freezes. All halving and quartering is done with arithmetic right shifts, so odd negative values round toward minus infinity. Products are carried at full width, and each result is brought back to the word width by a fixed, parameter-set right shift that keeps the low bits.

Top module: `motion_tensor_pipe`

## Requirements
- R1: The diagonal terms are a1 = floor(2·(x4 − y4)/4) and a4 = floor(2·(x5 − y5)/4). Here xK and yK are coefficient K of the earlier and later frame, and each coefficient is a signed two's-complement W-bit lane. In the packed input, lane K−2 holds coefficient K, so C2 sits at bits [W−1:0] and C6 at bits [5W−1:4W].
- R2: The single off-diagonal term is a2 = floor((x6 − y6)/4). It serves both off-diagonal positions of A.
- R3: The difference vector is b1 = floor((x2 − y2)/2) and b2 = floor((x3 − y3)/2).
- R4: g1 = a1² + a2² and g4 = a2² + a4².
- R5: g2 = a2·(a1 + a4), which equals both off-diagonal entries of G.
- R6: h1 = a1·b1 + a2·b2 and h2 = a2·b1 + a4·b2.
- R7: A pixel accepted at a rising edge at which out_ready is high appears on the outputs with out_valid high after exactly three advancing edges, where an advancing edge is one sampled with out_ready high. Edges that accept no pixel produce out_valid low in the same slot.
- R8: While out_ready is low, no stage moves. out_valid and all five results hold their values, and neither input is accepted.
- R9: f1_ready equals out_ready AND f2_valid, and f2_ready equals out_ready AND f1_valid. A pixel is taken only when both valids are high together with out_ready, so a lone valid is never consumed.
- R10: Each output is computed as (full-precision sum >>> OUT_SHIFT), and only its low W bits are kept.
- R11: While rst_n is low, out_valid is low. After reset the pipeline is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| f1_valid | input | 1 | Earlier-frame coefficients valid |
| f1_ready | output | 1 | Earlier-frame channel ready |
| f1_coef | input | 5·W | Earlier-frame C2..C6, C2 in the low lane |
| f2_valid | input | 1 | Later-frame coefficients valid |
| f2_ready | output | 1 | Later-frame channel ready |
| f2_coef | input | 5·W | Later-frame C2..C6, C2 in the low lane |
| out_valid | output | 1 | Results valid |
| out_ready | input | 1 | Consumer ready; low stalls the whole pipeline |
| g1 | output | W | G entry (1,1) |
| g2 | output | W | G off-diagonal entry |
| g4 | output | W | G entry (2,2) |
| h1 | output | W | First h element |
| h2 | output | W | Second h element |

## Verification
Nearly every internal fault reaches the ports within three advancing edges. A wrong shift, sign extension or lane pick changes one or more of the five results in the slot where that pixel emerges. A stage that advances during a stall, or a lost valid bit, shows up as out_valid in the wrong cycle or as data that changes under a held stall. The bench therefore keeps a behavioural three-slot model that advances only on ready edges. It compares valid on every cycle and data on every valid cycle, using extreme, odd-negative and random coefficients.

// File: rtl/motion_tensor_pipe.sv
module motion_tensor_pipe #(
  parameter int W         = 25,
  parameter int OUT_SHIFT = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                f1_valid,
  output logic                f1_ready,
  input  logic [5*W-1:0]      f1_coef,
  input  logic                f2_valid,
  output logic                f2_ready,
  input  logic [5*W-1:0]      f2_coef,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] g1,
  output logic signed [W-1:0] g2,
  output logic signed [W-1:0] g4,
  output logic signed [W-1:0] h1,
  output logic signed [W-1:0] h2
);
  localparam int W1 = W + 1;
  localparam int W2 = W + 2;
  localparam int P  = 2 * W1;
  localparam int S  = P + 1;

  logic en, take;
  assign en       = out_ready;
  assign take     = en & f1_valid & f2_valid;
  assign f1_ready = en & f2_valid;
  assign f2_ready = en & f1_valid;

  // lane 0..4 = C2..C6
  logic signed [W1-1:0] dif [5];
  for (genvar k = 0; k < 5; k++) begin : g_dif
    assign dif[k] = W1'($signed(f1_coef[k*W +: W])) - W1'($signed(f2_coef[k*W +: W]));
  end

  logic signed [W2-1:0] dbl4, dbl5;
  logic signed [W1-1:0] a1_n, a2_n, a4_n, b1_n, b2_n;
  assign dbl4 = {dif[2], 1'b0};
  assign dbl5 = {dif[3], 1'b0};
  assign a1_n = W1'(dbl4 >>> 2);
  assign a4_n = W1'(dbl5 >>> 2);
  assign a2_n = dif[4] >>> 2;
  assign b1_n = dif[0] >>> 1;
  assign b2_n = dif[1] >>> 1;

  logic                 v1, v2;
  logic signed [W1-1:0] a1, a2, a4, s14, b1, b2;
  logic signed [P-1:0]  p11, p22, p44, pg2, q1, q2, q3, q4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
    end else if (en) begin
      v1        <= take;
      v2        <= v1;
      out_valid <= v2;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      a1  <= a1_n;
      a2  <= a2_n;
      a4  <= a4_n;
      s14 <= a1_n + a4_n;
      b1  <= b1_n;
      b2  <= b2_n;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      p11 <= P'(a1) * P'(a1);
      p22 <= P'(a2) * P'(a2);
      p44 <= P'(a4) * P'(a4);
      pg2 <= P'(a2) * P'(s14);
      q1  <= P'(a1) * P'(b1);
      q2  <= P'(a2) * P'(b2);
      q3  <= P'(a2) * P'(b1);
      q4  <= P'(a4) * P'(b2);
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      g1 <= W'((S'(p11) + S'(p22)) >>> OUT_SHIFT);
      g2 <= W'(S'(pg2) >>> OUT_SHIFT);
      g4 <= W'((S'(p22) + S'(p44)) >>> OUT_SHIFT);
      h1 <= W'((S'(q1) + S'(q2)) >>> OUT_SHIFT);
      h2 <= W'((S'(q3) + S'(q4)) >>> OUT_SHIFT);
    end
  end

  a_r9_joint_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (f1_valid && f1_ready) |-> (f2_valid && f2_ready));

  a_r8_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> (!f1_ready && !f2_ready));

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(g1) && $stable(g2)
      && $stable(g4) && $stable(h1) && $stable(h2)));

  a_r7_to_out: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && v2) |=> out_valid);

  a_r7_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !v2) |=> !out_valid);
endmodule

// File: tb/motion_tensor_pipe_tb.sv
`timescale 1ns/1ps
module motion_tensor_pipe_tb;
  localparam int W  = 25;
  localparam int SH = 12;
  localparam longint MASK = (longint'(1) << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic f1_valid = 1'b0, f2_valid = 1'b0, out_ready = 1'b0;
  logic f1_ready, f2_ready, out_valid;
  logic [5*W-1:0] f1_coef = '0, f2_coef = '0;
  logic signed [W-1:0] g1, g2, g4, h1, h2;

  always #2.5 clk = ~clk;

  motion_tensor_pipe #(.W(W), .OUT_SHIFT(SH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .f1_valid(f1_valid), .f1_ready(f1_ready), .f1_coef(f1_coef),
    .f2_valid(f2_valid), .f2_ready(f2_ready), .f2_coef(f2_coef),
    .out_valid(out_valid), .out_ready(out_ready),
    .g1(g1), .g2(g2), .g4(g4), .h1(h1), .h2(h2));

  int checks = 0, errors = 0;
  bit done = 0;
  bit     mv [3];
  longint mo [3][5];
  longint c1 [5], c2 [5];
  bit     ap_f1v, ap_f2v, ap_or;
  longint ap_c1 [5], ap_c2 [5];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model(input longint x[5], input longint y[5], output longint o[5]);
    longint d[5];
    longint a1, a2, a4, b1, b2;
    for (int k = 0; k < 5; k++) d[k] = x[k] - y[k];
    a1 = (2 * d[2]) >>> 2;   // R1
    a4 = (2 * d[3]) >>> 2;   // R1
    a2 = d[4] >>> 2;         // R2
    b1 = d[0] >>> 1;         // R3
    b2 = d[1] >>> 1;         // R3
    o[0] = ((a1*a1 + a2*a2) >>> SH) & MASK;   // R4 R10
    o[1] = ((a1*a2 + a2*a4) >>> SH) & MASK;   // R5 R10
    o[2] = ((a2*a2 + a4*a4) >>> SH) & MASK;   // R4 R10
    o[3] = ((a1*b1 + a2*b2) >>> SH) & MASK;   // R6 R10
    o[4] = ((a2*b1 + a4*b2) >>> SH) & MASK;   // R6 R10
  endfunction

  function automatic longint rc(int mode);
    longint r;
    case (mode)
      0: r = longint'($urandom_range(0, 4000)) - 2000;
      1: case ($urandom_range(0, 4))
           0: r = (longint'(1) << (W-1)) - 1;
           1: r = -(longint'(1) << (W-1));
           2: r = 0;
           3: r = -1;
           default: r = 1;
         endcase
      default: begin
        r = longint'($urandom) & MASK;
        if (r >= (longint'(1) << (W-1))) r = r - (longint'(1) << W);
      end
    endcase
    return r;
  endfunction

  task automatic advance_model();
    longint o[5];
    if (ap_or) begin
      mv[2] = mv[1]; mo[2] = mo[1];
      mv[1] = mv[0]; mo[1] = mo[0];
      mv[0] = ap_f1v && ap_f2v;
      if (mv[0]) begin
        model(ap_c1, ap_c2, o);
        mo[0] = o;
      end
    end
  endtask

  task automatic compare();
    chk(out_valid == mv[2], "R7 R8 out_valid", longint'(out_valid), longint'(mv[2]));
    if (mv[2]) begin
      chk((longint'(g1) & MASK) == mo[2][0], "R1 R2 R4 R10 g1", longint'(g1) & MASK, mo[2][0]);
      chk((longint'(g2) & MASK) == mo[2][1], "R1 R2 R5 R10 g2", longint'(g2) & MASK, mo[2][1]);
      chk((longint'(g4) & MASK) == mo[2][2], "R1 R2 R4 R10 g4", longint'(g4) & MASK, mo[2][2]);
      chk((longint'(h1) & MASK) == mo[2][3], "R3 R6 R10 h1", longint'(h1) & MASK, mo[2][3]);
      chk((longint'(h2) & MASK) == mo[2][4], "R3 R6 R10 h2", longint'(h2) & MASK, mo[2][4]);
    end
  endtask

  task automatic drive(bit v1, bit v2, bit rdy, int mode);
    for (int k = 0; k < 5; k++) begin
      c1[k] = rc(mode);
      c2[k] = rc(mode);
      f1_coef[k*W +: W] = W'(c1[k]);
      f2_coef[k*W +: W] = W'(c2[k]);
    end
    f1_valid = v1; f2_valid = v2; out_ready = rdy;
    ap_f1v = v1; ap_f2v = v2; ap_or = rdy;
    ap_c1 = c1; ap_c2 = c2;
    #1;
    chk(f1_ready == (rdy & v2), "R9 f1_ready", longint'(f1_ready), longint'(rdy & v2));
    chk(f2_ready == (rdy & v1), "R9 f2_ready", longint'(f2_ready), longint'(rdy & v1));
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin mv[i] = 0; end
    ap_f1v = 0; ap_f2v = 0; ap_or = 0;
    for (int k = 0; k < 5; k++) begin ap_c1[k] = 0; ap_c2[k] = 0; end
    repeat (4) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R11 reset out_valid", longint'(out_valid), 0);
    end
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      advance_model();
      compare();
      if (cyc < 400)
        drive($urandom_range(0, 9) < 8, $urandom_range(0, 9) < 8, 1'b1, 0);
      else if (cyc < 800)
        drive(1'b1, 1'b1, $urandom_range(0, 9) < 9, 1);
      else if (cyc < 2400)
        drive($urandom_range(0, 9) < 7, $urandom_range(0, 9) < 7, $urandom_range(0, 9) < 7, 2);
      else if (cyc < 2500)
        drive(1'b1, 1'b0, 1'b1, 2);            // R9 lone earlier-frame valid
      else if (cyc < 2600)
        drive(1'b0, 1'b1, 1'b1, 2);            // R9 lone later-frame valid
      else if (cyc < 2700)
        drive(1'b1, 1'b1, cyc[2], 1);          // R8 regular stall pattern
      else
        drive(1'b0, 1'b0, 1'b1, 0);            // drain
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog expired act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule